// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This controller-side block brings a serial EEPROM that has lost step with its host back into a known state. The target may be holding the data line low because it is part-way through sending a byte or an acknowledge. The sequencer drives the two open-drain lines of the bus through active-high pull-down enables. It produces a fixed recovery waveform with four parts: a start condition, nine clock pulses with the data line released, a second start, and a stop. Each dummy pulse lets a target that is sending shift out one more bit, so the target lets go of the line within nine pulses. The start placed straight after the ninth pulse keeps a stray stop from being read as the end of a write.

The waveform is timed from the system clock. Every interval is a parameter counted in clock cycles: bus-free time, start hold, setup before a repeated start or a stop, clock low and high times, and the delay from a clock fall to a data change. The sequence runs once by itself when reset is released. After that it runs again on a one-cycle request pulse. `busy` covers the whole run, and `done` pulses once when it ends.

Top module: `bus_recover`

## Requirements
- R1: While reset is asserted, `scl_oe`, `sda_oe`, `busy` and `done` are all 0. An enable of 1 pulls its line low, and 0 releases it high.
- R2: After reset is released, one sequence runs with no request. No further sequence starts until `kick` is pulsed.
- R3: A `kick` sampled high while idle makes `busy` high in the next cycle. Both lines then stay released for T_BUF cycles before the first start.
- R4: A start is SDA falling while SCL is high. After the first start, SCL stays high for T_HOLD cycles before it falls.
- R5: SDA never changes in the same cycle as SCL. After the first SCL fall, SDA is released exactly T_DATA cycles later, while SCL is still low.
- R6: Exactly NCLK (9) SCL high pulses follow the first start, each T_HIGH cycles long, with SDA released throughout. Every low period after the first lasts exactly T_LOW cycles. The first low period lasts T_DATA + T_LOW cycles.
- R7: The second start (SDA falling, SCL high) comes T_HIGH + T_SETUP cycles after the last SCL rise, with no SCL fall in between.
- R8: The stop (SDA rising, SCL high) comes T_HOLD + T_SETUP cycles after the second start.
- R9: `done` is high for exactly one cycle, T_BUF cycles after the stop. `busy` falls in that same cycle, and both lines stay released while `busy` is low.
- R10: A `kick` that arrives while `busy` is high has no effect. The running sequence is unchanged, and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | One-cycle request to run the recovery sequence |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| busy | output | 1 | High from an accepted request until completion |
| done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The assertions assume that `kick` is a synchronous one-cycle pulse. They also assume that every timing parameter is at least 1 and that nothing else pulls the lines low, so each line level follows its enable. The bench drives `kick` only between clock edges and for a single cycle. It raises `kick` both while idle and at several points inside a running sequence. It watches the line levels derived from the enables and times every start, stop and edge against the parameter values, which is possible because no other driver shares the bus.

// File: rtl/recov_pkg.sv
package recov_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,    // lines released, waiting for a request
    PH_BUF,     // bus-free interval before the first start
    PH_STA1,    // first start: SDA low, SCL high
    PH_SDAREL,  // SCL low, SDA still low (data delay after fall)
    PH_CLO,     // SCL low, SDA released
    PH_CHI,     // SCL high, SDA released
    PH_RSU,     // setup before the repeated start
    PH_STA2,    // repeated start, then stop setup
    PH_FREE     // after stop, bus-free interval
  } phase_t;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } drive_t;

  function automatic drive_t phase_drive(phase_t p);
    drive_t d;
    d = '{scl_low: 1'b0, sda_low: 1'b0};
    case (p)
      PH_STA1:   d.sda_low = 1'b1;
      PH_SDAREL: begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
      PH_CLO:    d.scl_low = 1'b1;
      PH_STA2:   d.sda_low = 1'b1;
      default:   d = '{scl_low: 1'b0, sda_low: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/recov_timer.sv
module recov_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/recov_pulse_cnt.sv
module recov_pulse_cnt #(
  parameter int NCLK = 9,
  localparam int PW = $clog2(NCLK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == PW'(NCLK - 1));
endmodule

// File: rtl/recov_ctrl.sv
module recov_ctrl
  import recov_pkg::*;
#(
  parameter int  CW         = 8,
  parameter int  T_BUF      = 130,
  parameter int  T_HOLD     = 60,
  parameter int  T_SETUP    = 60,
  parameter int  T_LOW      = 100,
  parameter int  T_HIGH     = 90,
  parameter int  T_DATA     = 30,
  parameter bit  AUTO_START = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic          expired,
  input  logic          last_pulse,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          pulse_inc,
  output logic          pulse_clr,
  output phase_t        nxt,
  output logic          busy,
  output logic          done
);
  phase_t ph;
  logic   auto_pend;
  logic   go;

  function automatic logic [CW-1:0] dur_m1(phase_t p);
    case (p)
      PH_BUF, PH_FREE:  return CW'(T_BUF - 1);
      PH_STA1:          return CW'(T_HOLD - 1);
      PH_SDAREL:        return CW'(T_DATA - 1);
      PH_CLO:           return CW'(T_LOW - 1);
      PH_CHI:           return CW'(T_HIGH - 1);
      PH_RSU:           return CW'(T_SETUP - 1);
      PH_STA2:          return CW'(T_HOLD + T_SETUP - 1);
      default:          return '0;
    endcase
  endfunction

  assign go = kick | auto_pend;

  always_comb begin
    nxt       = ph;
    pulse_inc = 1'b0;
    if (ph == PH_IDLE) begin
      if (go) nxt = PH_BUF;
    end else if (expired) begin
      case (ph)
        PH_BUF:    nxt = PH_STA1;
        PH_STA1:   nxt = PH_SDAREL;
        PH_SDAREL: nxt = PH_CLO;
        PH_CLO:    nxt = PH_CHI;
        PH_CHI: begin
          pulse_inc = 1'b1;
          nxt       = last_pulse ? PH_RSU : PH_CLO;
        end
        PH_RSU:    nxt = PH_STA2;
        PH_STA2:   nxt = PH_FREE;
        default:   nxt = PH_IDLE;
      endcase
    end
    tmr_load = (nxt != ph);
    tmr_val  = dur_m1(nxt);
  end

  assign pulse_clr = (ph == PH_IDLE);
  assign busy      = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      auto_pend <= AUTO_START;
      done      <= 1'b0;
    end else begin
      ph   <= nxt;
      done <= (ph == PH_FREE) && expired;
      if (ph == PH_IDLE && go) auto_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/recov_drive.sv
module recov_drive
  import recov_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t nxt,
  output logic   scl_oe,
  output logic   sda_oe
);
  drive_t drv;

  assign drv = phase_drive(nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= drv.scl_low;
      sda_oe <= drv.sda_low;
    end
  end
endmodule

// File: rtl/bus_recover.sv
module bus_recover
  import recov_pkg::*;
#(
  parameter int NCLK       = 9,
  parameter int T_BUF      = 130,
  parameter int T_HOLD     = 60,
  parameter int T_SETUP    = 60,
  parameter int T_LOW      = 100,
  parameter int T_HIGH     = 90,
  parameter int T_DATA     = 30,
  parameter bit AUTO_START = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(T_BUF + T_HOLD + T_SETUP + T_LOW + T_HIGH + T_DATA + 1);

  logic          expired, last_pulse, tmr_load, pulse_inc, pulse_clr;
  logic [CW-1:0] tmr_val;
  phase_t        nxt;

  recov_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
  );

  recov_pulse_cnt #(.NCLK(NCLK)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clr(pulse_clr), .inc(pulse_inc), .last(last_pulse)
  );

  recov_ctrl #(
    .CW(CW), .T_BUF(T_BUF), .T_HOLD(T_HOLD), .T_SETUP(T_SETUP),
    .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_DATA(T_DATA), .AUTO_START(AUTO_START)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .kick(kick), .expired(expired),
    .last_pulse(last_pulse), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .pulse_inc(pulse_inc), .pulse_clr(pulse_clr), .nxt(nxt),
    .busy(busy), .done(done)
  );

  recov_drive u_drive (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/recov_checker.sv
module recov_checker #(
  parameter int NCLK = 9
) (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done
);
  localparam int PW = $clog2(NCLK + 2);
  logic [PW-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rises <= '0;
    else if (!busy)           rises <= '0;
    else if (scl_oe == 1'b0 && $past(scl_oe) == 1'b1) rises <= rises + 1'b1;
  end

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  assert_request_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && kick) |=> busy);

  assert_no_joint_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));

  assert_pulse_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises == PW'(NCLK)));
endmodule

bind bus_recover recov_checker #(.NCLK(NCLK)) u_recov_checker (
  .clk(clk), .rst_n(rst_n), .kick(kick), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .busy(busy), .done(done)
);

// File: tb/test_bus_recover.sv
module test_bus_recover;
  localparam int NCLK = 9, T_BUF = 13, T_HOLD = 6, T_SETUP = 6;
  localparam int T_LOW = 10, T_HIGH = 9, T_DATA = 3;
  localparam int NEV = 24;

  logic clk = 1'b0, rst_n = 1'b0, kick = 1'b0;
  logic scl_oe, sda_oe, busy, done;

  int checks = 0, errors = 0, cyc = 0;
  byte ev_c[64];
  int  ev_t[64];
  int  ev_n = 0;
  logic got_q = 1'b0;
  logic pscl = 1'b1, psda = 1'b1, pbusy = 1'b0;

  always #5 clk = ~clk;

  bus_recover #(
    .NCLK(NCLK), .T_BUF(T_BUF), .T_HOLD(T_HOLD), .T_SETUP(T_SETUP),
    .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_DATA(T_DATA), .AUTO_START(1'b1)
  ) i_bus_recover (
    .clk(clk), .rst_n(rst_n), .kick(kick), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .done(done)
  );

  task automatic add_ev(byte c);
    if (ev_n < 64) begin ev_c[ev_n] = c; ev_t[ev_n] = cyc; ev_n++; end
  endtask

  // Line monitor: line level is the inverse of its pull-down enable
  always @(negedge clk) begin
    logic scl, sda;
    cyc++;
    scl = ~scl_oe; sda = ~sda_oe;
    if (busy && !pbusy) add_ev("B");
    if (scl != pscl && sda != psda) add_ev("X");
    else if (scl != pscl) add_ev(scl ? "R" : "F");
    else if (sda != psda) begin
      if (scl) add_ev(sda ? "P" : "S");
      else     add_ev("D");
    end
    if (done) begin add_ev("Q"); got_q = 1'b1; end
    pscl = scl; psda = sda; pbusy = busy;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk);
    ev_n = 0; got_q = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  function automatic byte exp_code(int i);
    if (i == 0) return "B";
    if (i == 1) return "S";
    if (i == 2) return "F";
    if (i == 3) return "D";
    if (i <= 20) return (i % 2 == 0) ? "R" : "F";
    if (i == 21) return "S";
    if (i == 22) return "P";
    return "Q";
  endfunction

  function automatic int exp_gap(int i);
    if (i == 1) return T_BUF;
    if (i == 2) return T_HOLD;
    if (i == 3) return T_DATA;
    if (i == 4) return T_LOW;
    if (i <= 20) return (i % 2 == 1) ? T_HIGH : T_LOW;
    if (i == 21) return T_HIGH + T_SETUP;
    if (i == 22) return T_HOLD + T_SETUP;
    return T_BUF;
  endfunction

  function automatic string tag_of(int i);
    if (i <= 1) return "R3";
    if (i == 2) return "R4";
    if (i == 3) return "R5";
    if (i <= 20) return "R6";
    if (i == 21) return "R7";
    if (i == 22) return "R8";
    return "R9";
  endfunction

  // Wait for completion, then compare the logged waveform event by event
  task automatic check_sequence(string ctx);
    for (int k = 0; k < 4000 && !got_q; k++) @(negedge clk);
    @(negedge clk);
    check("R9", {ctx, " completion seen"}, int'(got_q), 1);
    check("R6", {ctx, " event count"}, ev_n, NEV);
    for (int i = 0; i < NEV && i < ev_n; i++) begin
      check(tag_of(i), $sformatf("%s event %0d code", ctx, i), int'(ev_c[i]), int'(exp_code(i)));
      if (i > 0)
        check(tag_of(i), $sformatf("%s gap before event %0d", ctx, i),
              ev_t[i] - ev_t[i-1], exp_gap(i));
    end
    check("R9", {ctx, " busy low after done"}, int'(busy), 0);
    check("R9", {ctx, " lines released"}, int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic check_quiet(string req, int n);
    clear_log();
    repeat (n) @(negedge clk);
    check(req, "no activity while idle", ev_n, 0);
    check(req, "busy stays low", int'(busy), 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1", "scl_oe in reset", int'(scl_oe), 0);
    check("R1", "sda_oe in reset", int'(sda_oe), 0);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
  endtask

  task automatic test_power_up();
    clear_log();
    @(negedge clk); rst_n = 1'b1;
    check_sequence("R2 power-up");
    check_quiet("R2", 300);
  endtask

  task automatic test_request();
    clear_log();
    pulse_kick();
    check("R3", "busy one cycle after kick", int'(busy), 1);
    check_sequence("R3 request");
  endtask

  task automatic test_ignore_busy();
    clear_log();
    pulse_kick();
    repeat (5) @(negedge clk);
    pulse_kick();
    repeat (60) @(negedge clk);
    pulse_kick();
    repeat (150) @(negedge clk);
    pulse_kick();
    check_sequence("R10 kicks while busy");
    check_quiet("R10", 300);
  endtask

  initial begin
    test_reset();
    test_power_up();
    test_request();
    test_ignore_busy();
    test_request();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule